// File: doc/BRIEF.md
# Split-Write Command Queue

This block sits between a host on a 16-bit register bus and a blitter engine that consumes 32-bit command words. Each command word reaches the queue in two bus writes: the host first writes the upper half to a holding register, then writes the lower half. Only the lower-half write puts the assembled word into the queue. The words leave on a valid/ready stream, one at a time. The engine signals the end of each operation with a one-cycle done pulse, and the next word is presented only after that pulse.

Software reads a pending count before it writes a burst. The count covers every word that is stored, staged or still executing, so it falls to zero only when the engine is idle. Before pushing n words, software waits until the count is at most the capacity minus n. A size register holds the capacity minus one. Reset sets it to the storage depth minus one, and software may lower it. A flush register empties the queue. A push that finds the queue at capacity is discarded and raises a sticky overflow flag.

Register offsets on the 3-bit address: 0 upper half (write latches, read returns the latched value), 1 lower half (write pushes), 2 pending count (read), 3 flush (write), 4 size (read/write), 5 status (read, bit 0 is the overflow flag). All other offsets read as zero.

Top module: `cmdq_split_fifo`

## Requirements
- R1: After reset the pending count is 0, the status register is 0, the size register reads DEPTH-1 (511 by default), and eng_valid is low.
- R2: A write to offset 0 only latches bits 31:16 and queues nothing. A write to offset 1 queues the word {latched upper half, written data}.
- R3: A write to offset 1 with no new write to offset 0 since the previous push reuses the last latched upper half.
- R4: Words leave on eng_data in the order they were accepted.
- R5: The pending count (offset 2) equals the number of stored words plus one while a word is staged on the output or executing. After a handshake, eng_valid stays low until eng_done pulses. While eng_valid is high and eng_ready is low, eng_data holds its value.
- R6: A push that arrives when the pending count equals size+1 is dropped. It leaves the pending count unchanged and sets status bit 0. That bit stays set until a flush.
- R7: A write to offset 3 with bit 0 set discards all stored and staged words, lowers eng_valid, and clears status bit 0. A word already taken by the engine still counts until eng_done. A write to offset 3 with bit 0 clear has no effect.
- R8: Writing offset 4 sets the capacity to the written value plus one. Values above DEPTH-1 are clamped to DEPTH-1, and the register reads back the stored value.
- R9: reg_rdata shows the register selected by reg_raddr one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Register write offset |
| reg_wdata | input | 16 | Register write data |
| reg_raddr | input | 3 | Register read offset |
| reg_rdata | output | 16 | Registered read data |
| eng_valid | output | 1 | Command word presented to the engine |
| eng_data | output | 32 | Command word |
| eng_ready | input | 1 | Engine accepts the presented word |
| eng_done | input | 1 | One-cycle pulse when the engine finishes an operation |

## Verification
The bench checks that the pending count still includes a word after its handshake and drops only on the done pulse. A design that counted only stored words would show zero while the engine is busy and let software overrun it. Lower-half writes with no fresh upper half are checked for reuse of the latched value; a design that cleared the latch would emit zero upper bits. The bench fills a shrunken queue past its capacity and checks that the extra word disappears and the overflow flag stays set. It then flushes while a word is staged and while one is executing. A flush that failed to retract the staged word, or that forgot the executing one, would produce a wrong count or a stale output.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_HI    = 3'd0,
    RA_LO    = 3'd1,
    RA_PEND  = 3'd2,
    RA_FLUSH = 3'd3,
    RA_SIZE  = 3'd4,
    RA_STAT  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/cmdq_regif.sv
module cmdq_regif #(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned DEPTH = 512,
  parameter int unsigned CNT_W = 10,
  localparam int unsigned WORD_W = 2 * BUS_W
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [cmdq_pkg::ADDR_W-1:0] waddr,
  input  logic [BUS_W-1:0]            wdata,
  input  logic [cmdq_pkg::ADDR_W-1:0] raddr,
  input  logic [CNT_W-1:0]            pend,
  input  logic                        drop,
  output logic                        push,
  output logic [WORD_W-1:0]           push_word,
  output logic                        flush,
  output logic [CNT_W-1:0]            size_q,
  output logic                        ovf_q,
  output logic [BUS_W-1:0]            rdata
);
  import cmdq_pkg::*;

  localparam logic [BUS_W-1:0] SIZE_MAX = BUS_W'(DEPTH - 1);

  logic [BUS_W-1:0] hi_q;

  assign push      = we && (waddr == RA_LO);
  assign flush     = we && (waddr == RA_FLUSH) && wdata[0];
  assign push_word = {hi_q, wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q   <= '0;
      size_q <= CNT_W'(DEPTH - 1);
      ovf_q  <= 1'b0;
    end else begin
      if (we && waddr == RA_HI)
        hi_q <= wdata;
      if (we && waddr == RA_SIZE)
        size_q <= (wdata > SIZE_MAX) ? CNT_W'(SIZE_MAX) : CNT_W'(wdata);
      if (flush)
        ovf_q <= 1'b0;
      else if (drop)
        ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (raddr)
        RA_HI:   rdata <= hi_q;
        RA_PEND: rdata <= BUS_W'(pend);
        RA_SIZE: rdata <= BUS_W'(size_q);
        RA_STAT: rdata <= {{(BUS_W-1){1'b0}}, ovf_q};
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cmdq_store.sv
module cmdq_store #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 512,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              re,
  input  logic [IDX_W-1:0]  raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/cmdq_ctrl.sv
module cmdq_ctrl #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned CNT_W  = 10,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              flush,
  input  logic [CNT_W-1:0]  size,
  input  logic              eng_ready,
  input  logic              eng_done,
  input  logic [WORD_W-1:0] mem_q,
  output logic              mem_we,
  output logic [IDX_W-1:0]  mem_waddr,
  output logic              mem_re,
  output logic [IDX_W-1:0]  mem_raddr,
  output logic              drop,
  output logic [CNT_W-1:0]  pend,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] stored;
  logic             rd_pend, busy_q;
  logic             inflight, accept, issue;
  logic [CNT_W-1:0] cap;

  assign inflight  = rd_pend | out_valid | busy_q;
  assign pend      = stored + {{(CNT_W-1){1'b0}}, inflight};
  assign cap       = size + CNT_W'(1);
  assign accept    = push && (pend < cap);
  assign drop      = push && !accept;
  assign issue     = !inflight && (stored != '0) && !flush;

  assign mem_we    = accept;
  assign mem_waddr = wr_ptr;
  assign mem_re    = issue;
  assign mem_raddr = rd_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      stored <= '0;
    end else if (flush) begin
      rd_ptr <= wr_ptr;
      stored <= '0;
    end else begin
      if (accept)
        wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + IDX_W'(1);
      if (issue)
        rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + IDX_W'(1);
      case ({accept, issue})
        2'b10:   stored <= stored + CNT_W'(1);
        2'b01:   stored <= stored - CNT_W'(1);
        default: stored <= stored;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_pend   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      busy_q    <= 1'b0;
    end else begin
      rd_pend <= issue;
      if (rd_pend && !flush)
        out_data <= mem_q;
      if (flush)
        out_valid <= 1'b0;
      else if (rd_pend)
        out_valid <= 1'b1;
      else if (out_valid && eng_ready)
        out_valid <= 1'b0;
      if (out_valid && eng_ready)
        busy_q <= 1'b1;
      else if (eng_done)
        busy_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cmdq_split_fifo.sv
module cmdq_split_fifo #(
  parameter int unsigned BUS_W = 16,
  parameter int unsigned DEPTH = 512,
  localparam int unsigned WORD_W = 2 * BUS_W,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_we,
  input  logic [cmdq_pkg::ADDR_W-1:0] reg_waddr,
  input  logic [BUS_W-1:0]            reg_wdata,
  input  logic [cmdq_pkg::ADDR_W-1:0] reg_raddr,
  output logic [BUS_W-1:0]            reg_rdata,
  output logic                        eng_valid,
  output logic [WORD_W-1:0]           eng_data,
  input  logic                        eng_ready,
  input  logic                        eng_done
);
  logic              push, flush, drop, ovf_q;
  logic [WORD_W-1:0] push_word, mem_q;
  logic [CNT_W-1:0]  size_q, pend_cnt;
  logic              mem_we, mem_re;
  logic [IDX_W-1:0]  mem_waddr, mem_raddr;

  cmdq_regif #(.BUS_W(BUS_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wdata(reg_wdata),
    .raddr(reg_raddr), .pend(pend_cnt), .drop(drop), .push(push),
    .push_word(push_word), .flush(flush), .size_q(size_q), .ovf_q(ovf_q),
    .rdata(reg_rdata)
  );

  cmdq_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(push_word),
    .re(mem_re), .raddr(mem_raddr), .rdata(mem_q)
  );

  cmdq_ctrl #(.WORD_W(WORD_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst(rst), .push(push), .flush(flush), .size(size_q),
    .eng_ready(eng_ready), .eng_done(eng_done), .mem_q(mem_q),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_re(mem_re),
    .mem_raddr(mem_raddr), .drop(drop), .pend(pend_cnt),
    .out_valid(eng_valid), .out_data(eng_data)
  );
endmodule

// File: rtl/cmdq_split_fifo_chk.sv
module cmdq_split_fifo_chk #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned CNT_W  = 10
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        we,
  input logic [cmdq_pkg::ADDR_W-1:0] waddr,
  input logic                        wbit0,
  input logic                        eng_valid,
  input logic                        eng_ready,
  input logic [WORD_W-1:0]           eng_data,
  input logic [CNT_W-1:0]            pend,
  input logic [CNT_W-1:0]            size,
  input logic                        ovf
);
  logic flush_w;
  assign flush_w = we && (waddr == cmdq_pkg::RA_FLUSH) && wbit0;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!eng_valid && pend == '0 && !ovf));

  assert_hold_stall_R5: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && !eng_ready && !flush_w) |=> (eng_valid && $stable(eng_data)));

  assert_one_inflight_R5: assert property (@(posedge clk) disable iff (rst)
    (eng_valid && eng_ready) |=> !eng_valid);

  assert_within_cap_R6: assert property (@(posedge clk) disable iff (rst)
    pend <= size + 1);

  assert_sticky_ovf_R6: assert property (@(posedge clk) disable iff (rst)
    (ovf && !flush_w) |=> ovf);

  assert_flush_clears_R7: assert property (@(posedge clk) disable iff (rst)
    flush_w |=> (!ovf && !eng_valid));

  assert_size_clamped_R8: assert property (@(posedge clk) disable iff (rst)
    size <= CNT_W'(DEPTH - 1));
endmodule

bind cmdq_split_fifo cmdq_split_fifo_chk #(
  .DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .we(reg_we), .waddr(reg_waddr), .wbit0(reg_wdata[0]),
  .eng_valid(eng_valid), .eng_ready(eng_ready), .eng_data(eng_data),
  .pend(pend_cnt), .size(size_q), .ovf(ovf_q)
);

// File: tb/cmdq_split_fifo_bench.sv
`timescale 1ns/1ps
module cmdq_split_fifo_bench;
  localparam int unsigned DEPTH = 512;
  localparam logic [2:0] A_HI = 3'd0, A_LO = 3'd1, A_PEND = 3'd2,
                         A_FLUSH = 3'd3, A_SIZE = 3'd4, A_STAT = 3'd5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_waddr = '0;
  logic [15:0] reg_wdata = '0;
  logic [2:0]  reg_raddr = '0;
  logic [15:0] reg_rdata;
  logic        eng_valid;
  logic [31:0] eng_data;
  logic        eng_ready = 1'b0;
  logic        eng_done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  cmdq_split_fifo u_cmdq_split_fifo (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
    .eng_valid(eng_valid), .eng_data(eng_data), .eng_ready(eng_ready),
    .eng_done(eng_done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    reg_raddr = a;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic expect_reg(input logic [2:0] a, input logic [15:0] exp,
                            input string tag);
    logic [15:0] v;
    rd(a, v);
    check(v == exp, tag, 32'(v), 32'(exp));
  endtask

  task automatic push(input logic [31:0] w);
    wr(A_HI, w[31:16]);
    wr(A_LO, w[15:0]);
  endtask

  task automatic take(input logic [31:0] exp, input bit finish, input string tag);
    for (int i = 0; i < 20 && !eng_valid; i++) @(negedge clk);
    check(eng_valid === 1'b1, {tag, " valid"}, 32'(eng_valid), 32'd1);
    check(eng_data === exp, tag, eng_data, exp);
    eng_ready = 1'b1;
    @(negedge clk);
    eng_ready = 1'b0;
    if (finish) begin
      eng_done = 1'b1;
      @(negedge clk);
      eng_done = 1'b0;
    end
  endtask

  task automatic pulse_done();
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic t_reset();
    check(eng_valid == 1'b0, "R1 valid after reset", 32'(eng_valid), 32'd0);
    expect_reg(A_PEND, 16'd0, "R1 pending after reset");
    expect_reg(A_STAT, 16'd0, "R1 status after reset");
    expect_reg(A_SIZE, 16'(DEPTH - 1), "R1 R9 size after reset");
  endtask

  task automatic t_split();
    wr(A_HI, 16'hABCD);
    expect_reg(A_PEND, 16'd0, "R2 upper write queues nothing");
    expect_reg(A_HI, 16'hABCD, "R2 R9 latched upper readback");
    repeat (3) @(negedge clk);
    check(eng_valid == 1'b0, "R2 no word after upper write", 32'(eng_valid), 32'd0);
    wr(A_LO, 16'h1234);
    expect_reg(A_PEND, 16'd1, "R2 lower write pushes");
    take(32'hABCD1234, 1'b1, "R2 assembled word");
    expect_reg(A_PEND, 16'd0, "R2 drained");
  endtask

  task automatic t_reuse_hi();
    wr(A_HI, 16'h5555);
    wr(A_LO, 16'h0001);
    wr(A_LO, 16'h0002);
    wr(A_LO, 16'h0003);
    expect_reg(A_PEND, 16'd3, "R3 three pushes counted");
    take(32'h55550001, 1'b1, "R3 first reuse");
    take(32'h55550002, 1'b1, "R3 second reuse");
    take(32'h55550003, 1'b1, "R3 third reuse");
  endtask

  task automatic t_order();
    logic [31:0] w [4] = '{32'h11112222, 32'hDEADBEEF, 32'h00000000, 32'hFFFF0F0F};
    for (int i = 0; i < 4; i++) push(w[i]);
    for (int i = 0; i < 4; i++) take(w[i], 1'b1, "R4 order");
    expect_reg(A_PEND, 16'd0, "R4 empty after drain");
  endtask

  task automatic t_inflight();
    push(32'hA0A0_0001);
    push(32'hA0A0_0002);
    take(32'hA0A0_0001, 1'b0, "R5 first word");
    expect_reg(A_PEND, 16'd2, "R5 executing word still pending");
    repeat (4) @(negedge clk);
    check(eng_valid == 1'b0, "R5 no second word while busy", 32'(eng_valid), 32'd0);
    pulse_done();
    expect_reg(A_PEND, 16'd1, "R5 count drops on done");
    take(32'hA0A0_0002, 1'b0, "R5 second word");
    expect_reg(A_PEND, 16'd1, "R5 count held until done");
    pulse_done();
    expect_reg(A_PEND, 16'd0, "R5 idle count zero");
  endtask

  task automatic t_overflow();
    wr(A_SIZE, 16'd3);
    expect_reg(A_SIZE, 16'd3, "R8 size readback");
    for (int i = 0; i < 5; i++) push(32'hC0DE_0000 + 32'(i));
    expect_reg(A_PEND, 16'd4, "R6 count stops at capacity");
    expect_reg(A_STAT, 16'd1, "R6 overflow set");
    for (int i = 0; i < 4; i++) take(32'hC0DE_0000 + 32'(i), 1'b1, "R6 kept words");
    repeat (4) @(negedge clk);
    check(eng_valid == 1'b0, "R6 dropped word absent", 32'(eng_valid), 32'd0);
    expect_reg(A_STAT, 16'd1, "R6 overflow sticky");
    expect_reg(A_PEND, 16'd0, "R6 drained");
  endtask

  task automatic t_flush();
    push(32'hF1F1_0001);
    push(32'hF1F1_0002);
    push(32'hF1F1_0003);
    wr(A_FLUSH, 16'h0000);
    expect_reg(A_PEND, 16'd3, "R7 flush with bit0 clear ignored");
    expect_reg(A_STAT, 16'd1, "R7 status kept on ignored flush");
    check(eng_valid == 1'b1, "R7 word still staged", 32'(eng_valid), 32'd1);
    wr(A_FLUSH, 16'h0001);
    check(eng_valid == 1'b0, "R7 staged word retracted", 32'(eng_valid), 32'd0);
    expect_reg(A_PEND, 16'd0, "R7 flush empties");
    expect_reg(A_STAT, 16'd0, "R7 flush clears overflow");
    push(32'hF2F2_0001);
    push(32'hF2F2_0002);
    take(32'hF2F2_0001, 1'b0, "R7 word after flush");
    wr(A_FLUSH, 16'h0001);
    expect_reg(A_PEND, 16'd1, "R7 executing word survives flush");
    pulse_done();
    expect_reg(A_PEND, 16'd0, "R7 idle after done");
    repeat (4) @(negedge clk);
    check(eng_valid == 1'b0, "R7 flushed word never shown", 32'(eng_valid), 32'd0);
  endtask

  task automatic t_size();
    wr(A_SIZE, 16'hFFFF);
    expect_reg(A_SIZE, 16'(DEPTH - 1), "R8 size clamped");
    wr(A_SIZE, 16'd0);
    push(32'h0BAD_0001);
    push(32'h0BAD_0002);
    expect_reg(A_PEND, 16'd1, "R8 capacity one");
    expect_reg(A_STAT, 16'd1, "R8 R6 second push dropped");
    take(32'h0BAD_0001, 1'b1, "R8 single word");
    wr(A_FLUSH, 16'h0001);
    wr(A_SIZE, 16'(DEPTH - 1));
    expect_reg(A_SIZE, 16'(DEPTH - 1), "R8 size restored");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_split();
    t_reuse_hi();
    t_order();
    t_inflight();
    t_overflow();
    t_flush();
    t_size();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule